// File: doc/BRIEF.md
# Vector Context CSR Swap Unit

This block holds the control registers that steer a vector execution loop: the maximum vector length, the current vector length, the subvector length, a packed state word that carries all three lengths together with the loop offsets, and a sub-execution program counter. A single request port reads, writes, sets or clears any of these registers. Each request is answered one cycle later with a read value and an illegal-value flag. A write that would store an unrepresentable length is refused and flagged.

The lengths are held in the state word biased by one, so a length of zero cannot be encoded. The block also keeps one banked copy of the state word and of the sub-PC for each of the User, Supervisor and Machine levels. A trap entry or a trap return naming a level swaps the live pair with that level's bank. Code running at each level therefore keeps its own vector context, without any save or restore sequence.

Top module: `vctx_csr_unit`

## Requirements
- R1: After reset the live state word, the live sub-PC and all three banks are zero, which encodes every length as 1. No response is pending.
- R2: State word layout for the default sizes: bits [5:0] hold MVL-1, bits [11:6] hold VL-1 and bits [13:12] hold SUBVL-1. Bits [19:14], [25:20], [27:26] and [29:28] hold the source, destination, subvector-source and subvector-destination offsets.
- R3: A request with any of the following outcomes is illegal: a resulting MVL or VL of 0 or above 64, a resulting SUBVL of 0 or above 4, or a selector above 4. An illegal request raises rsp_illegal together with rsp_valid for one cycle, returns zero data and leaves the live registers unchanged.
- R4: With csr_imm set, the operand is csr_wdata[4:0]. For the VL selector the operand is csr_wdata[4:0]+1, so immediates 0 to 31 give VL 1 to 32.
- R5: A VL result larger than the current MVL is clamped to MVL. An MVL write below the current VL lowers VL to the new MVL.
- R6: The response data for MVL, SUBVL, STATE and PCVLIW is the value before the request. For VL it is the value after the request, including any clamp.
- R7: csr_op encodes 0 read, 1 write, 2 set bits and 3 clear bits. For the three lengths, set and clear act on the natural length value (1 to 64), not on its biased encoding. A read never changes state.
- R8: The selectors are encoded 0 MVL, 1 VL, 2 SUBVL, 3 STATE and 4 PCVLIW. Each request accepted at a clock edge yields exactly one response, with rsp_valid high for that one following cycle only.
- R9: trap_enter or trap_return with trap_level 0 (User), 1 (Supervisor) or 3 (Machine) swaps the live state word and sub-PC with that level's bank. The swap is the same for both trap directions. Level 2 causes no swap.
- R10: A CSR request presented in the same cycle as any trap pulse is dropped: it produces no response and no register change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_req | input | 1 | CSR request strobe |
| csr_op | input | 2 | Operation: read, write, set, clear |
| csr_sel | input | 3 | Register selector |
| csr_imm | input | 1 | Use the 5-bit immediate form of the operand |
| csr_wdata | input | XLEN | Write operand |
| trap_enter | input | 1 | Trap entry pulse |
| trap_return | input | 1 | Trap return pulse |
| trap_level | input | 2 | Privilege level being entered or left |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_illegal | output | 1 | Request refused because of an illegal value |
| rsp_data | output | XLEN | Read value of the request |
| live_state | output | 4*LEN_W+3*SUB_W | Live packed state word |
| live_pc | output | PC_W | Live sub-execution program counter |

## Verification
The hardest situation to reach is a banked context that differs from the live one: the banks can only be seen by swapping them into the live registers. The stimulus enters a level, writes a distinct context there and returns. It then re-enters the same level and checks that the saved context comes back, while another level's bank still holds its own value. Clamping is reached by first lowering MVL below a large VL, and then writing VL above the new MVL.

// File: rtl/vctx_pkg.sv
package vctx_pkg;
   localparam logic [1:0] OP_READ  = 2'd0;
   localparam logic [1:0] OP_WRITE = 2'd1;
   localparam logic [1:0] OP_SET   = 2'd2;
   localparam logic [1:0] OP_CLEAR = 2'd3;

   localparam logic [2:0] SEL_MVL   = 3'd0;
   localparam logic [2:0] SEL_VL    = 3'd1;
   localparam logic [2:0] SEL_SUBVL = 3'd2;
   localparam logic [2:0] SEL_STATE = 3'd3;
   localparam logic [2:0] SEL_PC    = 3'd4;

   localparam logic [1:0] LVL_USER  = 2'd0;
   localparam logic [1:0] LVL_SUPER = 2'd1;
   localparam logic [1:0] LVL_MACH  = 2'd3;
   localparam int         NUM_LVL   = 3;
   localparam int         IMM_W     = 5;
endpackage

// File: rtl/vctx_len_eval.sv
module vctx_len_eval #(
   parameter int XLEN = 32,
   parameter int MAXV = 64
) (
   input  logic [1:0]      op_i,
   input  logic [XLEN-1:0] cur_i,
   input  logic [XLEN-1:0] operand_i,
   output logic [XLEN-1:0] nxt_o,
   output logic            bad_o
);
   import vctx_pkg::*;

   always_comb begin
      case (op_i)
         OP_WRITE: nxt_o = operand_i;
         OP_SET:   nxt_o = cur_i | operand_i;
         OP_CLEAR: nxt_o = cur_i & ~operand_i;
         default:  nxt_o = cur_i;
      endcase
      bad_o = (nxt_o == '0) || (nxt_o > XLEN'(MAXV));
   end
endmodule

// File: rtl/vctx_bank.sv
module vctx_bank #(
   parameter int STATE_W = 30,
   parameter int PC_W    = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               swap_en,
   input  logic [STATE_W-1:0] live_state_i,
   input  logic [PC_W-1:0]    live_pc_i,
   output logic [STATE_W-1:0] bank_state_o,
   output logic [PC_W-1:0]    bank_pc_o
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bank_state_o <= '0;
         bank_pc_o    <= '0;
      end else if (swap_en) begin
         bank_state_o <= live_state_i;
         bank_pc_o    <= live_pc_i;
      end
   end
endmodule

// File: rtl/vctx_csr_unit.sv
module vctx_csr_unit #(
   parameter int XLEN  = 32,
   parameter int LEN_W = 6,
   parameter int SUB_W = 2,
   parameter int PC_W  = 16
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       csr_req,
   input  logic [1:0]                 csr_op,
   input  logic [2:0]                 csr_sel,
   input  logic                       csr_imm,
   input  logic [XLEN-1:0]            csr_wdata,
   input  logic                       trap_enter,
   input  logic                       trap_return,
   input  logic [1:0]                 trap_level,
   output logic                       rsp_valid,
   output logic                       rsp_illegal,
   output logic [XLEN-1:0]            rsp_data,
   output logic [4*LEN_W+3*SUB_W-1:0] live_state,
   output logic [PC_W-1:0]            live_pc
);
   import vctx_pkg::*;

   localparam int STATE_W = 4*LEN_W + 3*SUB_W;
   localparam int MAX_LEN = 1 << LEN_W;
   localparam int MAX_SUB = 1 << SUB_W;
   localparam int MVL_LO  = 0;
   localparam int VL_LO   = LEN_W;
   localparam int SUB_LO  = 2*LEN_W;

   initial begin
      if (STATE_W > XLEN) $fatal(1, "state word wider than XLEN");
      if (PC_W > XLEN)    $fatal(1, "sub-PC wider than XLEN");
      if (LEN_W < IMM_W)  $fatal(1, "length field narrower than immediate range");
   end

   function automatic logic [XLEN-1:0] bit_apply(input logic [1:0] op,
                                                 input logic [XLEN-1:0] cur,
                                                 input logic [XLEN-1:0] opnd);
      case (op)
         OP_WRITE: return opnd;
         OP_SET:   return cur | opnd;
         OP_CLEAR: return cur & ~opnd;
         default:  return cur;
      endcase
   endfunction

   logic [STATE_W-1:0] state_q, state_d;
   logic [PC_W-1:0]    pc_q, pc_d;

   // trap handling and banks
   logic                trap_any, swap_any;
   logic [NUM_LVL-1:0]  lvl_hit;
   logic [STATE_W-1:0]  bank_state [NUM_LVL];
   logic [PC_W-1:0]     bank_pc    [NUM_LVL];
   logic [STATE_W-1:0]  pick_state;
   logic [PC_W-1:0]     pick_pc;

   assign trap_any = trap_enter | trap_return;
   assign swap_any = trap_any & (|lvl_hit);

   for (genvar i = 0; i < NUM_LVL; i++) begin : g_bank
      localparam logic [1:0] CODE = (i == 0) ? LVL_USER : (i == 1) ? LVL_SUPER : LVL_MACH;
      assign lvl_hit[i] = (trap_level == CODE);
      vctx_bank #(.STATE_W(STATE_W), .PC_W(PC_W)) u_bank (
         .clk          (clk),
         .rst_n        (rst_n),
         .swap_en      (trap_any & lvl_hit[i]),
         .live_state_i (state_q),
         .live_pc_i    (pc_q),
         .bank_state_o (bank_state[i]),
         .bank_pc_o    (bank_pc[i])
      );
   end

   always_comb begin
      pick_state = '0;
      pick_pc    = '0;
      for (int i = 0; i < NUM_LVL; i++) begin
         if (lvl_hit[i]) begin
            pick_state = bank_state[i];
            pick_pc    = bank_pc[i];
         end
      end
   end

   // operand and length evaluation
   logic            fire;
   logic [XLEN-1:0] operand, cur_mvl, cur_vl, cur_sub;
   logic [XLEN-1:0] mvl_nxt, vl_nxt, sub_nxt, vl_fit;
   logic            mvl_bad, vl_bad, sub_bad;
   logic            illegal;
   logic [XLEN-1:0] rd_val;

   assign fire    = csr_req & ~trap_any;
   assign operand = csr_imm
                  ? XLEN'(csr_wdata[IMM_W-1:0]) + ((csr_sel == SEL_VL) ? XLEN'(1) : XLEN'(0))
                  : csr_wdata;
   assign cur_mvl = XLEN'(state_q[MVL_LO +: LEN_W]) + XLEN'(1);
   assign cur_vl  = XLEN'(state_q[VL_LO  +: LEN_W]) + XLEN'(1);
   assign cur_sub = XLEN'(state_q[SUB_LO +: SUB_W]) + XLEN'(1);

   vctx_len_eval #(.XLEN(XLEN), .MAXV(MAX_LEN)) u_eval_mvl (
      .op_i(csr_op), .cur_i(cur_mvl), .operand_i(operand), .nxt_o(mvl_nxt), .bad_o(mvl_bad));
   vctx_len_eval #(.XLEN(XLEN), .MAXV(MAX_LEN)) u_eval_vl (
      .op_i(csr_op), .cur_i(cur_vl), .operand_i(operand), .nxt_o(vl_nxt), .bad_o(vl_bad));
   vctx_len_eval #(.XLEN(XLEN), .MAXV(MAX_SUB)) u_eval_sub (
      .op_i(csr_op), .cur_i(cur_sub), .operand_i(operand), .nxt_o(sub_nxt), .bad_o(sub_bad));

   assign vl_fit = (vl_nxt > cur_mvl) ? cur_mvl : vl_nxt;

   always_comb begin
      state_d = state_q;
      pc_d    = pc_q;
      illegal = 1'b0;
      rd_val  = '0;
      case (csr_sel)
         SEL_MVL: begin
            illegal = mvl_bad;
            rd_val  = cur_mvl;
            state_d[MVL_LO +: LEN_W] = LEN_W'(mvl_nxt - XLEN'(1));
            if (cur_vl > mvl_nxt)
               state_d[VL_LO +: LEN_W] = LEN_W'(mvl_nxt - XLEN'(1));
         end
         SEL_VL: begin
            illegal = vl_bad;
            rd_val  = vl_fit;
            state_d[VL_LO +: LEN_W] = LEN_W'(vl_fit - XLEN'(1));
         end
         SEL_SUBVL: begin
            illegal = sub_bad;
            rd_val  = cur_sub;
            state_d[SUB_LO +: SUB_W] = SUB_W'(sub_nxt - XLEN'(1));
         end
         SEL_STATE: begin
            rd_val  = XLEN'(state_q);
            state_d = STATE_W'(bit_apply(csr_op, XLEN'(state_q), operand));
         end
         SEL_PC: begin
            rd_val = XLEN'(pc_q);
            pc_d   = PC_W'(bit_apply(csr_op, XLEN'(pc_q), operand));
         end
         default: illegal = 1'b1;
      endcase
      if (illegal) rd_val = '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q     <= '0;
         pc_q        <= '0;
         rsp_valid   <= 1'b0;
         rsp_illegal <= 1'b0;
         rsp_data    <= '0;
      end else begin
         rsp_valid   <= fire;
         rsp_illegal <= fire & illegal;
         rsp_data    <= fire ? rd_val : '0;
         if (swap_any) begin
            state_q <= pick_state;
            pc_q    <= pick_pc;
         end else if (fire && !illegal && csr_op != OP_READ) begin
            state_q <= state_d;
            pc_q    <= pc_d;
         end
      end
   end

   assign live_state = state_q;
   assign live_pc    = pc_q;
endmodule

// File: rtl/vctx_csr_unit_chk.sv
module vctx_csr_unit_chk #(
   parameter int XLEN  = 32,
   parameter int LEN_W = 6,
   parameter int SUB_W = 2,
   parameter int PC_W  = 16
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       csr_req,
   input logic [2:0]                 csr_sel,
   input logic                       trap_enter,
   input logic                       trap_return,
   input logic [1:0]                 trap_level,
   input logic                       rsp_valid,
   input logic                       rsp_illegal,
   input logic [XLEN-1:0]            rsp_data,
   input logic [4*LEN_W+3*SUB_W-1:0] live_state,
   input logic [PC_W-1:0]            live_pc
);
   // R8: an accepted request is answered in the next cycle
   a_r8_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_req && !trap_enter && !trap_return) |=> rsp_valid);

   // R10: a trap cycle produces no response
   a_r10_trap_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_enter || trap_return) |=> !rsp_valid);

   // R3: refused request leaves the live registers untouched and returns zero
   a_r3_illegal_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_illegal |-> (rsp_valid && rsp_data == '0 && $stable(live_state) && $stable(live_pc)));

   // R6: VL response equals the VL now held in the live state word
   a_r6_vl_new_value: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(csr_req && !trap_enter && !trap_return && csr_sel == 3'd1) && rsp_valid && !rsp_illegal)
      |-> rsp_data == XLEN'(live_state[2*LEN_W-1:LEN_W]) + XLEN'(1));

   // R9: enter then leave the same level restores the live context
   a_r9_swap_roundtrip: assert property (@(posedge clk) disable iff (!rst_n)
      ((trap_enter && trap_level == 2'd0) ##1 (trap_return && trap_level == 2'd0))
      |=> (live_state == $past(live_state, 2) && live_pc == $past(live_pc, 2)));
endmodule

bind vctx_csr_unit vctx_csr_unit_chk #(.XLEN(XLEN), .LEN_W(LEN_W), .SUB_W(SUB_W), .PC_W(PC_W)) u_chk (.*);

// File: tb/vctx_csr_unit_test.sv
module vctx_csr_unit_test;
   localparam int XLEN = 32;
   localparam int SW   = 30;
   localparam int PW   = 16;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            csr_req = 1'b0;
   logic [1:0]      csr_op = '0;
   logic [2:0]      csr_sel = '0;
   logic            csr_imm = 1'b0;
   logic [XLEN-1:0] csr_wdata = '0;
   logic            trap_enter = 1'b0, trap_return = 1'b0;
   logic [1:0]      trap_level = '0;
   logic            rsp_valid, rsp_illegal;
   logic [XLEN-1:0] rsp_data;
   logic [SW-1:0]   live_state;
   logic [PW-1:0]   live_pc;

   int checks = 0, errors = 0;

   vctx_csr_unit uut (.*);

   always #4 clk = ~clk;

   // reference model
   logic [SW-1:0] m_state = '0;
   logic [PW-1:0] m_pc = '0;
   logic [SW-1:0] m_bstate [3] = '{default: '0};
   logic [PW-1:0] m_bpc    [3] = '{default: '0};

   logic [XLEN-1:0] q_data [$];
   logic            q_ill  [$];
   string           q_tag  [$];

   function automatic logic [31:0] apply(input logic [1:0] op, input logic [31:0] cur, input logic [31:0] o);
      case (op)
         2'd1: return o;
         2'd2: return cur | o;
         2'd3: return cur & ~o;
         default: return cur;
      endcase
   endfunction

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic csr(input logic [1:0] op, input logic [2:0] sel, input logic [31:0] wd,
                      input bit imm, input string tag);
      logic [31:0] opnd, nat, mvl, vl, sub, exp;
      bit ill;
      mvl = {26'b0, m_state[5:0]} + 1;
      vl  = {26'b0, m_state[11:6]} + 1;
      sub = {30'b0, m_state[13:12]} + 1;
      opnd = imm ? ({27'b0, wd[4:0]} + ((sel == 3'd1) ? 1 : 0)) : wd;
      exp = 0; ill = 0;
      case (sel)
         3'd0: begin
            nat = apply(op, mvl, opnd);
            if (nat == 0 || nat > 64) ill = 1;
            else begin
               exp = mvl;
               if (op != 0) begin
                  m_state[5:0] = 6'(nat - 1);
                  if (vl > nat) m_state[11:6] = 6'(nat - 1);
               end
            end
         end
         3'd1: begin
            nat = apply(op, vl, opnd);
            if (nat == 0 || nat > 64) ill = 1;
            else begin
               if (nat > mvl) nat = mvl;
               exp = nat;
               if (op != 0) m_state[11:6] = 6'(nat - 1);
            end
         end
         3'd2: begin
            nat = apply(op, sub, opnd);
            if (nat == 0 || nat > 4) ill = 1;
            else begin
               exp = sub;
               if (op != 0) m_state[13:12] = 2'(nat - 1);
            end
         end
         3'd3: begin
            exp = {2'b0, m_state};
            if (op != 0) m_state = SW'(apply(op, {2'b0, m_state}, opnd));
         end
         3'd4: begin
            exp = {16'b0, m_pc};
            if (op != 0) m_pc = PW'(apply(op, {16'b0, m_pc}, opnd));
         end
         default: ill = 1;
      endcase
      q_data.push_back(exp);
      q_ill.push_back(ill);
      q_tag.push_back(tag);
      @(negedge clk);
      csr_req = 1; csr_op = op; csr_sel = sel; csr_wdata = wd; csr_imm = imm;
      @(negedge clk);
      csr_req = 0; csr_imm = 0;
   endtask

   task automatic trap(input bit enter, input logic [1:0] lvl, input bit with_req);
      int idx;
      @(negedge clk);
      trap_enter = enter; trap_return = !enter; trap_level = lvl;
      csr_req = with_req; csr_op = 2'd1; csr_sel = 3'd4; csr_wdata = 32'hBEEF;
      @(negedge clk);
      trap_enter = 0; trap_return = 0; csr_req = 0;
      idx = (lvl == 0) ? 0 : (lvl == 1) ? 1 : (lvl == 3) ? 2 : -1;
      if (idx >= 0) begin
         logic [SW-1:0] ts; logic [PW-1:0] tp;
         ts = m_state; tp = m_pc;
         m_state = m_bstate[idx]; m_pc = m_bpc[idx];
         m_bstate[idx] = ts; m_bpc[idx] = tp;
      end
   endtask

   task automatic check_live(input string tag);
      check(live_state == m_state, {tag, " state"}, {2'b0, live_state}, {2'b0, m_state});
      check(live_pc == m_pc, {tag, " pc"}, {16'b0, live_pc}, {16'b0, m_pc});
   endtask

   // monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         if (q_data.size() == 0) begin
            check(0, "R8/R10 unexpected response", rsp_data, 0);
         end else begin
            logic [31:0] ed; logic ei; string t;
            ed = q_data.pop_front(); ei = q_ill.pop_front(); t = q_tag.pop_front();
            check(rsp_illegal == ei, {t, " illegal flag"}, {31'b0, rsp_illegal}, {31'b0, ei});
            check(rsp_data == ed, {t, " data"}, rsp_data, ed);
         end
      end
   end

   initial begin
      #(8 * 20000);
      check(0, "watchdog", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      check(live_state == 0, "R1 reset state", {2'b0, live_state}, 0);
      check(live_pc == 0, "R1 reset pc", {16'b0, live_pc}, 0);
      check(!rsp_valid, "R1 no response", {31'b0, rsp_valid}, 0);
      csr(2'd0, 3'd0, 0, 0, "R1 read MVL");
      csr(2'd0, 3'd2, 0, 0, "R1 read SUBVL");

      // R2 / R6 layout and old-value returns
      csr(2'd1, 3'd0, 64, 0, "R6 MVL write returns old");
      check(live_state == 30'h3F, "R2 MVL field", {2'b0, live_state}, 32'h3F);
      csr(2'd1, 3'd1, 10, 0, "R6 VL write returns new");
      check(live_state[11:6] == 6'd9, "R2 VL field", {26'b0, live_state[11:6]}, 9);
      csr(2'd1, 3'd2, 3, 0, "R6 SUBVL write returns old");
      check(live_state[13:12] == 2'd2, "R2 SUBVL field", {30'b0, live_state[13:12]}, 2);
      csr(2'd1, 3'd2, 4, 0, "R3 SUBVL 4 legal");
      csr(2'd0, 3'd2, 0, 0, "R7 read SUBVL");

      // R4 immediate
      csr(2'd1, 3'd1, 31, 1, "R4 imm 31 gives 32");
      csr(2'd1, 3'd1, 0, 1, "R4 imm 0 gives 1");
      csr(2'd1, 3'd1, 32'hFFE5, 1, "R4 imm uses low bits");
      check_live("R4");

      // R3 illegal values
      csr(2'd1, 3'd1, 0, 0, "R3 VL zero");
      csr(2'd1, 3'd1, 65, 0, "R3 VL 65");
      csr(2'd1, 3'd0, 0, 0, "R3 MVL zero");
      csr(2'd1, 3'd0, 100, 0, "R3 MVL 100");
      csr(2'd1, 3'd2, 0, 0, "R3 SUBVL zero");
      csr(2'd1, 3'd2, 5, 0, "R3 SUBVL 5");
      csr(2'd1, 3'd6, 5, 0, "R3 bad selector");
      csr(2'd3, 3'd2, 32'h7, 0, "R3 SUBVL clear to zero");
      check_live("R3 unchanged");

      // R7 set/clear on natural lengths
      csr(2'd1, 3'd1, 8, 0, "R7 VL setup");
      csr(2'd2, 3'd1, 32'h20, 0, "R7 VL set bit");
      csr(2'd3, 3'd1, 32'h8, 0, "R7 VL clear bit");
      csr(2'd0, 3'd1, 32'h1234, 0, "R7 read ignores operand");
      csr(2'd2, 3'd1, 32'h40, 0, "R7 VL set too large");
      check_live("R7");

      // R5 clamping
      csr(2'd1, 3'd1, 50, 0, "R5 VL 50");
      csr(2'd1, 3'd0, 16, 0, "R5 MVL below VL");
      check(live_state[11:6] == 6'd15, "R5 VL pulled down", {26'b0, live_state[11:6]}, 15);
      csr(2'd1, 3'd1, 40, 0, "R5 VL clamped to MVL");
      check_live("R5");

      // STATE and PCVLIW raw access
      csr(2'd1, 3'd3, 32'h2ABC_D4C7, 0, "R6 STATE write old");
      csr(2'd0, 3'd3, 0, 0, "R6 STATE read");
      csr(2'd1, 3'd4, 32'h0001_5A5A, 0, "R6 PC write old");
      csr(2'd3, 3'd4, 32'h0000_000F, 0, "R7 PC clear");
      csr(2'd0, 3'd4, 0, 0, "R6 PC read");
      check_live("R6 raw");

      // R9 bank swaps
      trap(1, 2'd0, 0);
      check_live("R9 enter U");
      csr(2'd1, 3'd4, 32'h00AA, 0, "R9 U ctx pc");
      trap(0, 2'd0, 0);
      check_live("R9 return U");
      trap(1, 2'd1, 0);
      csr(2'd1, 3'd0, 20, 0, "R9 S ctx mvl");
      csr(2'd1, 3'd4, 32'h0055, 0, "R9 S ctx pc");
      trap(0, 2'd1, 0);
      check_live("R9 return S");
      trap(1, 2'd1, 0);
      check_live("R9 S ctx restored");
      trap(1, 2'd3, 0);
      check_live("R9 enter M");
      trap(0, 2'd3, 0);
      trap(1, 2'd2, 0);
      check_live("R9 level 2 ignored");
      trap(0, 2'd1, 0);
      trap(1, 2'd0, 0);
      check_live("R9 U bank kept");
      trap(0, 2'd0, 0);

      // R10 request during trap dropped
      trap(1, 2'd2, 1);
      check_live("R10 dropped on level 2 trap");
      trap(1, 2'd0, 1);
      check_live("R10 dropped on swap");
      trap(0, 2'd0, 0);
      check_live("R10 after return");

      repeat (3) @(negedge clk);
      check(q_data.size() == 0, "R8 all responses seen", q_data.size(), 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule